// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This peripheral keeps time as a single unsigned 32-bit count of seconds. An internal prescaler divides the input clock into a one-second tick, and the count advances on each tick while the counter is enabled. Software reaches the block through a small word-addressed register bus. It can read the current count and program a match value for an alarm. It can also stage a new count, which is only taken at the next tick. Four control bits set the interrupt enable, the interrupt mask, the counter enable and the wrap-on-match mode.

When the count, on a tick, becomes equal to the match value, an alarm flag is latched in raw status. This happens whatever the enable and mask bits hold. The interrupt line and the masked status show that flag only when the interrupt is enabled and not masked. A read of the acknowledge register clears the flag. Writes do not clear it. A read-only version register returns a build-time constant.

Top module: `secs_rtc`

## Requirements
- R1: After reset the count, the match value, the staged load value, the control bits and raw status all read 0, and the interrupt output is low.
- R2: The count advances by one every PRESCALE input clocks only while counter-enable (control bit 2) is 1. The first increment lands PRESCALE clocks after the write that sets the bit. While the bit is 0 the count holds, and the prescaler restarts from zero.
- R3: A write to the load register (word 2, byte offset 0x08) leaves the count unchanged until the next tick. On that tick the count takes the written value.
- R4: A staged load is applied in place of the increment on the tick where both apply. A load staged while counting is stopped waits for the first tick after the counter is enabled.
- R5: Raw status (word 5, offset 0x14, bit 0) is set when the count, on a tick, becomes equal to the match register (word 1, offset 0x04). This holds for interrupt enable and mask at any value.
- R6: The interrupt output and bit 0 of masked status (word 4, offset 0x10) are 1 only when raw status is 1, interrupt-enable (control bit 0) is 1 and interrupt-mask (control bit 1) is 0.
- R7: A read of the acknowledge register (word 6, offset 0x18) clears raw status at that clock edge and returns 0. An alarm arriving in the same cycle wins over the clear.
- R8: With wrap (control bit 3) set, a tick that finds the count equal to the match value sets the count to 0. With wrap clear, the count goes from 0xFFFFFFFF to 0.
- R9: Writes to the count (word 0), masked status, raw status, acknowledge and version (word 7, offset 0x1C) registers change nothing.
- R10: Match and load read back as written. The control register (word 3, offset 0x0C) keeps only bits 3:0, and its upper bits read 0. The version register returns the VERSION parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, divided down to the seconds tick |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_word | input | 3 | Register word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Alarm interrupt request, level |

## Verification
The hardest case to reach is an alarm that meets each mode at an exact tick. The count must land on the match value through a staged load, through a plain increment, and through rollover from 0xFFFFFFFF. With wrap set, it must also return to zero on the tick after the match. The bench reaches these points with a small prescaler. Before enabling the counter it stages a load a few seconds short of the match value, so each event falls at a tick position it can compute. It samples on the clock before the event and on the clock after it. Only then does it change the enable and mask bits and read the acknowledge register, so that the latching and the gating are seen separately.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;

    localparam int CNT_W  = 32;
    localparam int WORD_W = 3;

    typedef enum logic [WORD_W-1:0] {
        W_COUNT = 3'd0,
        W_MATCH = 3'd1,
        W_LOAD  = 3'd2,
        W_CTRL  = 3'd3,
        W_STAT  = 3'd4,
        W_RAW   = 3'd5,
        W_ACK   = 3'd6,
        W_VER   = 3'd7
    } reg_word_e;

    // bit 3 wrap, bit 2 run, bit 1 mask, bit 0 interrupt enable
    typedef struct packed {
        logic wrap;
        logic run;
        logic mask;
        logic ien;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // value the counter takes on a tick
    function automatic logic [CNT_W-1:0] next_count(
        input logic [CNT_W-1:0] cur,
        input logic [CNT_W-1:0] match,
        input logic             pend,
        input logic [CNT_W-1:0] staged,
        input logic             wrap
    );
        if (pend)
            return staged;
        else if (wrap && cur == match)
            return '0;
        else
            return cur + 1'b1;
    endfunction

endpackage

// File: rtl/secs_rtc_tick.sv
module secs_rtc_tick #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            pre_q <= '0;
        else if (pre_q == LAST)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    assign tick = run && (pre_q == LAST);

endmodule

// File: rtl/secs_rtc_counter.sv
module secs_rtc_counter
    import secs_rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] match,
    input  logic             ld_wr,
    input  logic [CNT_W-1:0] ld_data,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] staged,
    output logic             pend,
    output logic             hit
);
    logic [CNT_W-1:0] count_q, staged_q, nxt;
    logic             pend_q;

    assign nxt = next_count(count_q, match, pend_q, staged_q, wrap);
    assign hit = tick && (nxt == match);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            staged_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (tick)
                count_q <= nxt;
            if (ld_wr) begin
                staged_q <= ld_data;
                pend_q   <= 1'b1;
            end else if (tick) begin
                pend_q   <= 1'b0;
            end
        end
    end

    assign count  = count_q;
    assign staged = staged_q;
    assign pend   = pend_q;

endmodule

// File: rtl/secs_rtc_regs.sv
module secs_rtc_regs
    import secs_rtc_pkg::*;
#(
    parameter logic [CNT_W-1:0] VERSION = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  staged,
    input  logic              hit,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  match,
    output logic              raw,
    output logic              ld_wr,
    output logic              ack_rd,
    output logic              irq
);
    reg_word_e sel;
    ctrl_t     ctrl_q;
    logic [CNT_W-1:0] match_q;
    logic      raw_q;
    logic      pend_irq;

    assign sel    = reg_word_e'(bus_word);
    assign ld_wr  = bus_wr && (sel == W_LOAD);
    assign ack_rd = bus_rd && (sel == W_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            match_q <= '0;
            raw_q   <= 1'b0;
        end else begin
            if (bus_wr && sel == W_CTRL)
                ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (bus_wr && sel == W_MATCH)
                match_q <= bus_wdata;
            if (hit)
                raw_q <= 1'b1;
            else if (ack_rd)
                raw_q <= 1'b0;
        end
    end

    assign pend_irq = raw_q && ctrl_q.ien && !ctrl_q.mask;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                W_COUNT: bus_rdata = count;
                W_MATCH: bus_rdata = match_q;
                W_LOAD:  bus_rdata = staged;
                W_CTRL:  bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
                W_STAT:  bus_rdata = {{(CNT_W-1){1'b0}}, pend_irq};
                W_RAW:   bus_rdata = {{(CNT_W-1){1'b0}}, raw_q};
                W_ACK:   bus_rdata = '0;
                W_VER:   bus_rdata = VERSION;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign ctrl  = ctrl_q;
    assign match = match_q;
    assign raw   = raw_q;
    assign irq   = pend_irq;

endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import secs_rtc_pkg::*;
#(
    parameter int               PRESCALE = 32768,
    parameter logic [CNT_W-1:0] VERSION  = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl;
    logic             tick, hit, raw, ld_wr, ack_rd, pend;
    logic [CNT_W-1:0] count_q, staged, match;

    secs_rtc_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.run),
        .tick (tick)
    );

    secs_rtc_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wrap    (ctrl.wrap),
        .match   (match),
        .ld_wr   (ld_wr),
        .ld_data (bus_wdata),
        .count   (count_q),
        .staged  (staged),
        .pend    (pend),
        .hit     (hit)
    );

    secs_rtc_regs #(.VERSION(VERSION)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count_q),
        .staged    (staged),
        .hit       (hit),
        .ctrl      (ctrl),
        .match     (match),
        .raw       (raw),
        .ld_wr     (ld_wr),
        .ack_rd    (ack_rd),
        .irq       (irq)
    );

endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        hit,
    input logic        run,
    input logic        ien,
    input logic        mask,
    input logic        wrap,
    input logic        raw,
    input logic        irq,
    input logic        pend,
    input logic        ld_wr,
    input logic        ack_rd,
    input logic [31:0] count,
    input logic [31:0] match
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == 32'd0 && !irq && !raw));

    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

    assert_load_deferred_R3: assert property (@(posedge clk) disable iff (rst)
        (ld_wr && !tick) |=> $stable(count));

    assert_alarm_latch_R5: assert property (@(posedge clk) disable iff (rst)
        hit |=> raw);

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (!ien || mask) |-> !irq);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !hit) |=> !raw);

    assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && wrap && !pend && count == match) |=> (count == 32'd0));

endmodule

bind secs_rtc secs_rtc_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .hit    (hit),
    .run    (ctrl.run),
    .ien    (ctrl.ien),
    .mask   (ctrl.mask),
    .wrap   (ctrl.wrap),
    .raw    (raw),
    .irq    (irq),
    .pend   (pend),
    .ld_wr  (ld_wr),
    .ack_rd (ack_rd),
    .count  (count_q),
    .match  (match)
);

// File: tb/sim_secs_rtc.sv
`timescale 1ns/1ps
module sim_secs_rtc;
    localparam int          P   = 4;
    localparam logic [31:0] VER = 32'hA5C3_0107;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_word = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    secs_rtc #(.PRESCALE(P), .VERSION(VER)) u0 (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every bus task starts at a negedge and ends at the next one
    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] d);
        bus_rd = 1'b1; bus_word = w;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rdchk(input string req, input logic [2:0] w, input logic [31:0] exp);
        logic [31:0] v;
        rd(w, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rdchk("R1 count", 3'd0, 32'd0);
        rdchk("R1 match", 3'd1, 32'd0);
        rdchk("R1 load", 3'd2, 32'd0);
        rdchk("R1 ctrl", 3'd3, 32'd0);
        rdchk("R1 raw", 3'd5, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rdchk("R10 version", 3'd7, VER);

        // R10 readback and control width
        wr(3'd1, 32'h1234_5678);
        rdchk("R10 match readback", 3'd1, 32'h1234_5678);
        wr(3'd3, 32'hFFFF_FFF0);
        rdchk("R10 ctrl upper bits", 3'd3, 32'd0);
        wr(3'd2, 32'hCAFE_0001);
        rdchk("R10 load readback", 3'd2, 32'hCAFE_0001);
        idle(3 * P);
        rdchk("R4 stopped load waits", 3'd0, 32'd0);

        // R9 writes to read-only words
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'h0000_0000);
        rdchk("R9 count", 3'd0, 32'd0);
        rdchk("R9 raw", 3'd5, 32'd0);
        rdchk("R9 status", 3'd4, 32'd0);
        rdchk("R9 version", 3'd7, VER);

        // R2/R4 counting with a staged zero load
        wr(3'd2, 32'd0);
        wr(3'd1, 32'hFFFF_0000);
        wr(3'd3, 32'h4);
        idle(P - 1);
        rdchk("R2 before first tick", 3'd0, 32'd0);
        rdchk("R4 load beats increment", 3'd0, 32'd0);
        idle(P - 2);
        rdchk("R2 before second tick", 3'd0, 32'd0);
        rdchk("R2 second tick", 3'd0, 32'd1);
        for (int k = 2; k <= 6; k++) begin
            idle(P - 1);
            rdchk("R2 sweep", 3'd0, 32'(k));
        end

        // R3 load while running (now one clock past a tick)
        wr(3'd2, 32'd1000);
        rdchk("R3 no immediate change", 3'd0, 32'd6);
        idle(P - 4);
        rdchk("R3 before tick", 3'd0, 32'd6);
        rdchk("R3 taken at tick", 3'd0, 32'd1000);

        // R2 stop holds count
        wr(3'd3, 32'h0);
        idle(3 * P);
        rdchk("R2 stopped", 3'd0, 32'd1000);

        // R5/R6/R7 alarm
        wr(3'd2, 32'd10);
        wr(3'd1, 32'd12);
        rdchk("R7 ack reads zero", 3'd6, 32'd0);
        wr(3'd3, 32'h4);
        idle(3 * P - 1);
        rdchk("R5 raw before match", 3'd5, 32'd0);
        rdchk("R5 raw on match, ien off", 3'd5, 32'd1);
        chk("R6 irq off without enable", {31'd0, irq}, 32'd0);
        rdchk("R6 status off without enable", 3'd4, 32'd0);
        wr(3'd3, 32'h7);
        chk("R6 irq masked", {31'd0, irq}, 32'd0);
        rdchk("R6 status masked", 3'd4, 32'd0);
        rdchk("R5 raw while masked", 3'd5, 32'd1);
        wr(3'd3, 32'h5);
        chk("R6 irq enabled", {31'd0, irq}, 32'd1);
        rdchk("R6 status enabled", 3'd4, 32'd1);
        wr(3'd6, 32'd0);
        wr(3'd5, 32'd0);
        chk("R9 write does not ack", {31'd0, irq}, 32'd1);
        rdchk("R7 ack read value", 3'd6, 32'd0);
        chk("R7 irq cleared", {31'd0, irq}, 32'd0);
        rdchk("R7 raw cleared", 3'd5, 32'd0);

        // R8 wrap on match
        wr(3'd3, 32'h0);
        wr(3'd2, 32'd5);
        wr(3'd1, 32'd7);
        wr(3'd3, 32'hC);
        idle(4 * P - 1);
        rdchk("R8 at match", 3'd0, 32'd7);
        rdchk("R8 wrapped to zero", 3'd0, 32'd0);
        rdchk("R5 raw with wrap", 3'd5, 32'd1);

        // R8 natural rollover, alarm at zero
        wr(3'd3, 32'h0);
        rdchk("R7 ack", 3'd6, 32'd0);
        wr(3'd2, 32'hFFFF_FFFE);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'h4);
        idle(3 * P - 2);
        rdchk("R5 raw before rollover", 3'd5, 32'd0);
        rdchk("R8 top value", 3'd0, 32'hFFFF_FFFF);
        rdchk("R8 rolled over", 3'd0, 32'd0);
        rdchk("R5 alarm at rollover", 3'd5, 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule